// File: doc/BRIEF.md
# Pointer-Based Data Address Generator

This block computes the memory address for a load or store that names its location through a pointer. The pointer can be one of three 16-bit pointer registers, the stack pointer, or a 16-bit address carried in the instruction. The sequencer gives it the current pointer values, a pointer selector, an addressing mode, a 6-bit unsigned displacement and a direct address, and then pulses a request. The block holds the effective address steady for the whole operation. In the final cycle it raises done and, where the mode changes a pointer, a write-back strobe that carries the new pointer value and the pointer it belongs to.

The mode decides two things: whether the pointer moves, and whether the access uses the pointer before or after it moves. With post-increment, the access uses the old value and the pointer then advances. With pre-decrement, the pointer is reduced first and the access uses the reduced value. A displacement adds an offset to the address and leaves the pointer as it was, and the first pointer has no displacement form. Push and pop follow the same two orderings on the stack pointer. Program-memory accesses always address through the third pointer and flag the program space, and one load variant advances that pointer afterwards. All arithmetic wraps at 16 bits.

Top module: `ptr_addr_gen`

## Requirements
- R1: After reset, busy, done and wbEn are 0, and effAddr and progSpace are 0.
- R2: A request accepted while idle makes busy 1 for exactly two cycles, starting in the cycle after the request edge. done is 1 only in the second of those cycles, and busy is 0 in the cycle after done.
- R3: A request that arrives while busy is ignored. effAddr, the results and the timing of the current operation do not change, and no further operation follows.
- R4: Plain mode (mode 0) addresses the selected pointer (ptrSel 0 = first, 1 = second, 2 or 3 = third) and gives no write-back. Mode codes 10 to 15 behave like plain mode.
- R5: Post-increment (mode 1) addresses the old pointer value and writes back pointer+1 modulo 2^16 to the selected pointer.
- R6: Pre-decrement (mode 2) addresses pointer-1 modulo 2^16 and writes back that same value.
- R7: Displacement (mode 3) with the second or third pointer addresses pointer+disp, where disp is unsigned 0..63, modulo 2^16, and gives no write-back.
- R8: Displacement mode with the first pointer (ptrSel 0) ignores disp and addresses the pointer unchanged, with no write-back.
- R9: Direct mode (mode 4) addresses directAddr and gives no write-back.
- R10: Push (mode 5) addresses stackPtr and writes back stackPtr-1 with wbSel 3.
- R11: Pop (mode 6) addresses stackPtr+1 and writes back stackPtr+1 with wbSel 3.
- R12: The program-memory modes, load (7), load with post-increment (8) and store (9), set progSpace to 1 and address ptrZ whatever ptrSel is. Only mode 8 writes back, with ptrZ+1 and wbSel 2. All other modes set progSpace to 0.
- R13: wbEn is 1 only in the done cycle. wbSel names the pointer written back: 0, 1 or 2 for the three pointers and 3 for the stack pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start pulse, taken only when idle |
| mode | input | 4 | Addressing mode code |
| ptrSel | input | 2 | Pointer selector |
| disp | input | 6 | Unsigned displacement |
| directAddr | input | 16 | Address used in direct mode |
| ptrX | input | 16 | First pointer value |
| ptrY | input | 16 | Second pointer value |
| ptrZ | input | 16 | Third pointer value |
| stackPtr | input | 16 | Stack pointer value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final cycle of the operation |
| effAddr | output | 16 | Effective address, held while busy |
| progSpace | output | 1 | Address is in program memory |
| wbEn | output | 1 | Pointer write-back strobe |
| wbSel | output | 2 | Pointer to write back |
| wbData | output | 16 | New pointer value |

## Verification
Every cycle, the assertions check the handshake shape: done comes in the second busy cycle and busy falls after it, write-back happens only with done, the address does not change during an operation, and a program-space write-back always targets the third pointer. Whether each mode produces the right address and the right write-back value, including the order of update and access and the wrap at 0x0000 and 0xFFFF, can only be shown by the bench scenarios. The bench compares every completed operation against a model computed from the requirements.

// File: rtl/ptr_addr_pkg.sv
package ptr_addr_pkg;
  typedef enum logic [3:0] {
    MD_PLAIN   = 4'd0,
    MD_POSTINC = 4'd1,
    MD_PREDEC  = 4'd2,
    MD_DISP    = 4'd3,
    MD_DIRECT  = 4'd4,
    MD_PUSH    = 4'd5,
    MD_POP     = 4'd6,
    MD_PMLOAD  = 4'd7,
    MD_PMLDINC = 4'd8,
    MD_PMSTORE = 4'd9
  } addrMode_e;

  localparam logic [1:0] SEL_P0 = 2'd0;
  localparam logic [1:0] SEL_P1 = 2'd1;
  localparam logic [1:0] SEL_P2 = 2'd2;
  localparam logic [1:0] SEL_SP = 2'd3;

  typedef struct packed {
    logic capture;
    logic active;
    logic finish;
  } ctrlStrobe_t;
endpackage

// File: rtl/ptr_addr_ctrl.sv
module ptr_addr_ctrl
  import ptr_addr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        req,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done
);
  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_FIN} state_e;
  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (req) stateNext = ST_EXEC;
      ST_EXEC: stateNext = ST_FIN;
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign strobe.capture = (state == ST_IDLE) && req;
  assign strobe.active  = (state != ST_IDLE);
  assign strobe.finish  = (state == ST_FIN);
  assign busy = strobe.active;
  assign done = strobe.finish;

  // R2
  capture_then_exec_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (busy && !done));
  // R2
  exec_then_fin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> done);
endmodule

// File: rtl/ptr_addr_dp.sv
module ptr_addr_dp
  import ptr_addr_pkg::*;
#(
  parameter int AW = 16,
  parameter int QW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strobe,
  input  logic [3:0]    mode,
  input  logic [1:0]    ptrSel,
  input  logic [QW-1:0] disp,
  input  logic [AW-1:0] directAddr,
  input  logic [AW-1:0] ptrX,
  input  logic [AW-1:0] ptrY,
  input  logic [AW-1:0] ptrZ,
  input  logic [AW-1:0] stackPtr,
  output logic [AW-1:0] effAddr,
  output logic          progSpace,
  output logic          wbEn,
  output logic [1:0]    wbSel,
  output logic [AW-1:0] wbData
);
  localparam int PADW = AW - QW;

  logic [AW-1:0] base, nAddr, nData, dispExt;
  logic [1:0]    nSel;
  logic          nWb, nProg, pendWb;

  assign dispExt = {{PADW{1'b0}}, disp};

  always_comb begin
    case (ptrSel)
      SEL_P0:  base = ptrX;
      SEL_P1:  base = ptrY;
      default: base = ptrZ;
    endcase
    nAddr = base;
    nData = base;
    nSel  = (ptrSel == SEL_SP) ? SEL_P2 : ptrSel;
    nWb   = 1'b0;
    nProg = 1'b0;
    case (mode)
      MD_POSTINC: begin nWb = 1'b1; nData = base + 1'b1; end
      MD_PREDEC:  begin nAddr = base - 1'b1; nData = base - 1'b1; nWb = 1'b1; end
      MD_DISP:    if (ptrSel != SEL_P0) nAddr = base + dispExt;
      MD_DIRECT:  nAddr = directAddr;
      MD_PUSH:    begin nAddr = stackPtr; nData = stackPtr - 1'b1; nSel = SEL_SP; nWb = 1'b1; end
      MD_POP:     begin nAddr = stackPtr + 1'b1; nData = stackPtr + 1'b1; nSel = SEL_SP; nWb = 1'b1; end
      MD_PMLOAD, MD_PMSTORE: begin nAddr = ptrZ; nData = ptrZ; nSel = SEL_P2; nProg = 1'b1; end
      MD_PMLDINC: begin nAddr = ptrZ; nData = ptrZ + 1'b1; nSel = SEL_P2; nProg = 1'b1; nWb = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      effAddr   <= '0;
      wbData    <= '0;
      wbSel     <= SEL_P0;
      pendWb    <= 1'b0;
      progSpace <= 1'b0;
    end else if (strobe.capture) begin
      effAddr   <= nAddr;
      wbData    <= nData;
      wbSel     <= nSel;
      pendWb    <= nWb;
      progSpace <= nProg;
    end
  end

  assign wbEn = strobe.finish && pendWb;

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.active && !strobe.capture) |=> (!strobe.active || $stable(effAddr)));
  // R12
  prog_wb_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbEn && progSpace) |-> (wbSel == SEL_P2));
endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen
  import ptr_addr_pkg::*;
#(
  parameter int AW = 16,
  parameter int QW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          req,
  input  logic [3:0]    mode,
  input  logic [1:0]    ptrSel,
  input  logic [QW-1:0] disp,
  input  logic [AW-1:0] directAddr,
  input  logic [AW-1:0] ptrX,
  input  logic [AW-1:0] ptrY,
  input  logic [AW-1:0] ptrZ,
  input  logic [AW-1:0] stackPtr,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] effAddr,
  output logic          progSpace,
  output logic          wbEn,
  output logic [1:0]    wbSel,
  output logic [AW-1:0] wbData
);
  ctrlStrobe_t strobe;

  ptr_addr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .req(req),
    .strobe(strobe), .busy(busy), .done(done)
  );

  ptr_addr_dp #(.AW(AW), .QW(QW)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .mode(mode), .ptrSel(ptrSel), .disp(disp), .directAddr(directAddr),
    .ptrX(ptrX), .ptrY(ptrY), .ptrZ(ptrZ), .stackPtr(stackPtr),
    .effAddr(effAddr), .progSpace(progSpace),
    .wbEn(wbEn), .wbSel(wbSel), .wbData(wbData)
  );

  // R13
  wb_only_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> done);
  // R2
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  // R2
  done_inside_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
endmodule

// File: tb/ptr_addr_gen_tb_top.sv
module ptr_addr_gen_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic req = 1'b0;
  logic [3:0] mode = '0;
  logic [1:0] ptrSel = '0;
  logic [5:0] disp = '0;
  logic [15:0] directAddr = '0, ptrX = '0, ptrY = '0, ptrZ = '0, stackPtr = '0;
  logic busy, done, progSpace, wbEn;
  logic [15:0] effAddr, wbData;
  logic [1:0] wbSel;

  int checks = 0;
  int fails = 0;

  typedef struct {
    string tag;
    logic [15:0] addr;
    logic prog;
    logic wb;
    logic [1:0] sel;
    logic [15:0] data;
  } expItem_t;

  expItem_t sbq[$];

  always #5 clk = ~clk;

  ptr_addr_gen dut_i (
    .clk(clk), .rstN(rstN), .req(req), .mode(mode), .ptrSel(ptrSel),
    .disp(disp), .directAddr(directAddr), .ptrX(ptrX), .ptrY(ptrY),
    .ptrZ(ptrZ), .stackPtr(stackPtr), .busy(busy), .done(done),
    .effAddr(effAddr), .progSpace(progSpace), .wbEn(wbEn),
    .wbSel(wbSel), .wbData(wbData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic expItem_t model(input string tag, input logic [3:0] m, input logic [1:0] s,
                                     input logic [5:0] q);
    expItem_t e;
    logic [15:0] p;
    p = (s == 2'd0) ? ptrX : (s == 2'd1) ? ptrY : ptrZ;
    e.tag = tag; e.addr = p; e.prog = 1'b0; e.wb = 1'b0;
    e.sel = (s == 2'd3) ? 2'd2 : s; e.data = p;
    case (m)
      4'd1: begin e.wb = 1'b1; e.data = p + 16'd1; end
      4'd2: begin e.addr = p - 16'd1; e.data = p - 16'd1; e.wb = 1'b1; end
      4'd3: if (s != 2'd0) e.addr = p + {10'd0, q};
      4'd4: e.addr = directAddr;
      4'd5: begin e.addr = stackPtr; e.data = stackPtr - 16'd1; e.sel = 2'd3; e.wb = 1'b1; end
      4'd6: begin e.addr = stackPtr + 16'd1; e.data = stackPtr + 16'd1; e.sel = 2'd3; e.wb = 1'b1; end
      4'd7, 4'd9: begin e.addr = ptrZ; e.data = ptrZ; e.sel = 2'd2; e.prog = 1'b1; end
      4'd8: begin e.addr = ptrZ; e.data = ptrZ + 16'd1; e.sel = 2'd2; e.prog = 1'b1; e.wb = 1'b1; end
      default: ;
    endcase
    return e;
  endfunction

  // Monitor: compares each finished operation with the head of the queue
  always @(negedge clk) begin
    if (rstN) begin
      if (wbEn && !done) chk("R13 wbEn outside done", 1, 0);
      if (done) begin
        if (sbq.size() == 0) chk("R2 unexpected done", 1, 0);
        else begin
          expItem_t e;
          e = sbq.pop_front();
          chk({e.tag, " addr"}, effAddr, e.addr);
          chk({e.tag, " progSpace"}, progSpace, e.prog);
          chk({e.tag, " R13 wbEn"}, wbEn, e.wb);
          if (e.wb) begin
            chk({e.tag, " R13 wbSel"}, wbSel, e.sel);
            chk({e.tag, " wbData"}, wbData, e.data);
          end
        end
      end
    end
  end

  // Driver: starts one operation, optionally pulses a second request while busy
  task automatic runOp(input string tag, input logic [3:0] m, input logic [1:0] s,
                       input logic [5:0] q, input bit pokeBusy);
    expItem_t e;
    @(negedge clk);
    mode = m; ptrSel = s; disp = q; req = 1'b1;
    e = model(tag, m, s, q);
    sbq.push_back(e);
    @(negedge clk);
    req = 1'b0;
    chk({tag, " R2 busy exec"}, busy, 1);
    chk({tag, " R2 done exec"}, done, 0);
    chk({tag, " exec addr"}, effAddr, e.addr);
    if (pokeBusy) begin
      mode = 4'd4; directAddr = ~e.addr; req = 1'b1;
    end
    @(negedge clk);
    req = 1'b0;
    chk({tag, " R2 done fin"}, done, 1);
    @(negedge clk);
    chk({tag, " R2 idle after"}, busy, 0);
    if (pokeBusy) begin
      @(negedge clk);
      chk({tag, " R3 no extra op"}, busy, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 wbEn", wbEn, 0);
    chk("R1 effAddr", effAddr, 0);
    chk("R1 progSpace", progSpace, 0);
    rstN = 1'b1;

    ptrX = 16'h1234; ptrY = 16'hFFFF; ptrZ = 16'hFFF0; stackPtr = 16'h0000;
    directAddr = 16'hBEEF;
    runOp("R4 plain X", 4'd0, 2'd0, 6'd5, 0);
    runOp("R4 plain sel3", 4'd0, 2'd3, 6'd0, 0);
    runOp("R4 undefined mode", 4'd12, 2'd1, 6'd0, 0);
    runOp("R5 postinc X", 4'd1, 2'd0, 6'd0, 0);
    runOp("R5 postinc Y wrap", 4'd1, 2'd1, 6'd0, 0);
    runOp("R6 predec Z", 4'd2, 2'd2, 6'd0, 0);
    ptrX = 16'h0000;
    runOp("R6 predec X wrap", 4'd2, 2'd0, 6'd0, 0);
    runOp("R7 disp Z wrap 63", 4'd3, 2'd2, 6'd63, 0);
    runOp("R7 disp Y 0", 4'd3, 2'd1, 6'd0, 0);
    ptrY = 16'h0100;
    runOp("R7 disp Y 17", 4'd3, 2'd1, 6'd17, 0);
    ptrX = 16'h4000;
    runOp("R8 disp X ignored", 4'd3, 2'd0, 6'd40, 0);
    runOp("R9 direct", 4'd4, 2'd1, 6'd0, 0);
    runOp("R10 push wrap", 4'd5, 2'd0, 6'd0, 0);
    stackPtr = 16'hFFFF;
    runOp("R11 pop wrap", 4'd6, 2'd2, 6'd0, 0);
    stackPtr = 16'h0250;
    runOp("R10 push", 4'd5, 2'd1, 6'd0, 0);
    runOp("R11 pop", 4'd6, 2'd0, 6'd0, 0);
    ptrZ = 16'h0800;
    runOp("R12 pm load", 4'd7, 2'd0, 6'd0, 0);
    runOp("R12 pm load inc", 4'd8, 2'd1, 6'd0, 0);
    ptrZ = 16'hFFFF;
    runOp("R12 pm load inc wrap", 4'd8, 2'd2, 6'd0, 0);
    runOp("R12 pm store", 4'd9, 2'd0, 6'd0, 0);
    ptrY = 16'h7777;
    runOp("R3 req while busy", 4'd1, 2'd1, 6'd0, 1);
    directAddr = 16'h0042;
    runOp("R9 direct after poke", 4'd4, 2'd0, 6'd0, 0);

    repeat (2) @(negedge clk);
    chk("R2 queue drained", sbq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule